// File: doc/BRIEF.md
# Multiplexed Conversion Sequencer

This block is the digital controller for an eight-input multiplexed sampling front end. It decides which input configuration the analog multiplexer and gain stage see for each conversion. It pulses the converter to start, and waits for the converter's done handshake. It then publishes the result together with the multiplexer field that produced it. Each configuration names one of eight channels and selects single-ended or differential input, input polarity swap, unipolar or bipolar coding, and one of two gain ranges.

The controller has two modes. When no list is stored, it scans channels 0 to 7 in a loop with a default configuration. When a list is stored, it walks the list entries and returns to the first entry after the last. Software fills the list one word at a time over a chip-select, write and read bus. The same parallel bus returns conversion words, and it can also return the stored list for inspection. All strobes are synchronous, single-clock-domain signals. The converter is modelled only as a start pulse and a done pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the controller is idle: `busy_o` and `conv_go_o` are low, the bus enable is low, the stored list is empty, the multiplexer outputs select single-ended channel 0 with all option bits low, and the latched conversion word is zero.
- R2: With an empty list, successive conversions use channels 0,1,...,7 and then 0 again. In this mode the differential, swap, bipolar and gain outputs are all low.
- R3: A `conv_start_i` pulse while idle raises `busy_o` on the next clock. On that same clock `conv_go_o` is high for exactly one cycle, and the multiplexer outputs present the configuration of the current entry.
- R4: A `conv_start_i` pulse while busy is ignored. It produces no `conv_go_o` pulse, and the multiplexer outputs do not change.
- R5: `conv_done_i` while busy latches the conversion word {differential flag [15], channel address [14:12], result [11:0]} and clears `busy_o` on the next clock. `conv_done_i` while idle leaves the word unchanged.
- R6: A write (`sel_i` and `wr_i` high, `ctl_i` low) appends `cfg_i` at the next list position. The `cfg_i` fields are: bit 6 differential, bits 5:3 channel, bit 2 swap, bit 1 bipolar, bit 0 gain. Conversions then follow the list order and return to entry 0 after the last entry.
- R7: Once the list holds DEPTH (16) entries, further appending writes are ignored.
- R8: A write with `ctl_i` high empties the list, so the controller returns to scanning from channel 0. Any write that changes the list restarts the conversion pointer at entry 0.
- R9: `data_en_o` is high exactly while `sel_i` and `rd_i` are both high. With `ctl_i` low, `data_o` carries the last conversion word.
- R10: A read with `ctl_i` high places the 7-bit entry at the readback position on `data_o[15:9]`, with bits 8:0 zero. The readback position moves to the next entry when the read strobe ends, and returns to entry 0 after the last entry. An empty list reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip select, active high |
| wr_i | input | 1 | Write strobe, one cycle per word |
| rd_i | input | 1 | Read strobe |
| ctl_i | input | 1 | Qualifier: clear on write, list readback on read |
| cfg_i | input | 7 | Configuration word to append |
| conv_start_i | input | 1 | Request one conversion |
| conv_done_i | input | 1 | Converter finished |
| conv_res_i | input | 12 | Converter result |
| conv_go_o | output | 1 | One-cycle start pulse to converter |
| busy_o | output | 1 | Conversion in progress |
| mux_addr_o | output | 3 | Multiplexer channel address |
| mux_diff_o | output | 1 | Differential input select |
| mux_swap_o | output | 1 | Input polarity swap |
| mux_bip_o | output | 1 | Bipolar coding select |
| mux_gain_o | output | 1 | Gain range select |
| data_o | output | 16 | Parallel data bus value |
| data_en_o | output | 1 | Drive enable for the bus pads (high-impedance when low) |

## Verification
The assertions assume that the converter answers only to a start it was given. This means `conv_done_i` arrives after `conv_go_o` and at most once per conversion, and the strobes are synchronous one-cycle or level signals that contain no glitches. The bench drives every input on the falling clock edge. It raises done only after it has seen busy, and it always lets a read strobe end before it issues the next one. The one exception is a deliberate stray done pulse while idle, which the controller is required to ignore.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NCH = 8;
  localparam int CH_W = 3;

  typedef struct packed {
    logic            diff;
    logic [CH_W-1:0] addr;
    logic            swap;
    logic            bip;
    logic            gain;
  } seq_cfg_t;

  localparam int CFG_W = $bits(seq_cfg_t);
endpackage

// File: rtl/seq_store.sv
module seq_store
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             app_i,
  input  logic             clr_i,
  input  seq_cfg_t         cfg_i,
  output logic [LEN_W-1:0] len_o,
  input  logic [IDX_W-1:0] run_idx_i,
  output seq_cfg_t         run_cfg_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output seq_cfg_t         rb_cfg_o
);
  seq_cfg_t          mem [DEPTH];
  logic [LEN_W-1:0]  len_q, len_d;
  logic              full, wr_en;

  assign full  = (len_q == LEN_W'(DEPTH));
  assign wr_en = app_i && !clr_i && !full;

  always_comb begin
    len_d = len_q;
    if (clr_i)      len_d = '0;
    else if (wr_en) len_d = len_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[len_q[IDX_W-1:0]] <= cfg_i;
  end

  assign len_o     = len_q;
  assign run_cfg_o = mem[run_idx_i];
  assign rb_cfg_o  = mem[rb_idx_i];

  // R7
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_W'(DEPTH));
endmodule

// File: rtl/seq_walk.sv
module seq_walk
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0] wrap_at;

  assign wrap_at = (len_i != '0) ? len_i - 1'b1 : LEN_W'(NCH - 1);

  always_comb begin
    ptr_d = ptr_q;
    if (restart_i)  ptr_d = '0;
    else if (adv_i) ptr_d = (LEN_W'(ptr_q) == wrap_at) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    LEN_W'(ptr_q) <= wrap_at);
endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12,
  localparam int WORD_W = RES_W + 1 + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              done_i,
  input  seq_cfg_t          cfg_i,
  input  logic [RES_W-1:0]  res_i,
  output logic              busy_o,
  output logic              go_o,
  output logic              adv_o,
  output seq_cfg_t          act_o,
  output logic [WORD_W-1:0] word_o
);
  logic              busy_q, busy_d, go_q, go_d;
  logic              take, fin;
  seq_cfg_t          act_q, act_d;
  logic [WORD_W-1:0] word_q, word_d;

  assign take = start_i && !busy_q;
  assign fin  = done_i && busy_q;

  always_comb begin
    busy_d = busy_q;
    act_d  = act_q;
    word_d = word_q;
    go_d   = take;
    if (take) begin
      busy_d = 1'b1;
      act_d  = cfg_i;
    end
    if (fin) begin
      busy_d = 1'b0;
      word_d = {act_q.diff, act_q.addr, res_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      go_q   <= 1'b0;
      act_q  <= '0;
      word_q <= '0;
    end else begin
      busy_q <= busy_d;
      go_q   <= go_d;
      act_q  <= act_d;
      word_q <= word_d;
    end
  end

  assign busy_o = busy_q;
  assign go_o   = go_q;
  assign adv_o  = fin;
  assign act_o  = act_q;
  assign word_o = word_q;

  // R3
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> !go_q);
  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> go_q);
  // R4
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(act_q));
  // R5
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done_i));
  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy_q) |-> $stable(word_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RES_W = 12,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int BUS_W = RES_W + 1 + CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             ctl_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             conv_start_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_res_i,
  output logic             conv_go_o,
  output logic             busy_o,
  output logic [CH_W-1:0]  mux_addr_o,
  output logic             mux_diff_o,
  output logic             mux_swap_o,
  output logic             mux_bip_o,
  output logic             mux_gain_o,
  output logic [BUS_W-1:0] data_o,
  output logic             data_en_o
);
  logic             rst_m, rst_s;
  logic             app_ev, clr_ev, chg_ev, rb_act, rb_prev_q, rb_end;
  logic             adv, list_mode;
  logic [LEN_W-1:0] len;
  logic [IDX_W-1:0] run_ptr, rb_ptr;
  seq_cfg_t         run_cfg, rb_cfg, cur_cfg, act_cfg, rb_vis;
  logic [BUS_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign app_ev = sel_i && wr_i && !ctl_i;
  assign clr_ev = sel_i && wr_i && ctl_i;
  assign chg_ev = app_ev || clr_ev;
  assign rb_act = sel_i && rd_i && ctl_i;
  assign rb_end = rb_prev_q && !rb_act;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rb_prev_q <= 1'b0;
    else        rb_prev_q <= rb_act;
  end

  seq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_s), .app_i(app_ev), .clr_i(clr_ev),
    .cfg_i(seq_cfg_t'(cfg_i)), .len_o(len),
    .run_idx_i(run_ptr), .run_cfg_o(run_cfg),
    .rb_idx_i(rb_ptr), .rb_cfg_o(rb_cfg)
  );

  seq_walk #(.DEPTH(DEPTH)) u_run_walk (
    .clk(clk), .rst_n(rst_s), .restart_i(chg_ev), .adv_i(adv),
    .len_i(len), .ptr_o(run_ptr)
  );

  seq_walk #(.DEPTH(DEPTH)) u_rb_walk (
    .clk(clk), .rst_n(rst_s), .restart_i(chg_ev), .adv_i(rb_end),
    .len_i(len), .ptr_o(rb_ptr)
  );

  assign list_mode = (len != '0);

  always_comb begin
    cur_cfg      = '0;
    cur_cfg.addr = run_ptr[CH_W-1:0];
    if (list_mode) cur_cfg = run_cfg;
    rb_vis = list_mode ? rb_cfg : '0;
  end

  conv_ctrl #(.RES_W(RES_W)) u_conv (
    .clk(clk), .rst_n(rst_s), .start_i(conv_start_i), .done_i(conv_done_i),
    .cfg_i(cur_cfg), .res_i(conv_res_i), .busy_o(busy_o), .go_o(conv_go_o),
    .adv_o(adv), .act_o(act_cfg), .word_o(word)
  );

  assign mux_addr_o = act_cfg.addr;
  assign mux_diff_o = act_cfg.diff;
  assign mux_swap_o = act_cfg.swap;
  assign mux_bip_o  = act_cfg.bip;
  assign mux_gain_o = act_cfg.gain;

  assign data_en_o = sel_i && rd_i;
  assign data_o    = ctl_i ? {rb_vis, {(BUS_W-CFG_W){1'b0}}} : word;

  // R2
  scan_plain_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ($rose(busy_o) && !$past(list_mode)) |-> (act_cfg.diff == 1'b0 && act_cfg.bip == 1'b0));
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_s)
    chg_ev |=> (run_ptr == '0 && rb_ptr == '0));
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 0, wr = 0, rd = 0, ctl = 0, start = 0, done = 0;
  logic [6:0]  cfg = '0;
  logic [11:0] res = '0;
  logic        go, busy, diff, swap, bip, gain, den;
  logic [2:0]  addr;
  logic [15:0] bus;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .wr_i(wr), .rd_i(rd), .ctl_i(ctl),
    .cfg_i(cfg), .conv_start_i(start), .conv_done_i(done), .conv_res_i(res),
    .conv_go_o(go), .busy_o(busy), .mux_addr_o(addr), .mux_diff_o(diff),
    .mux_swap_o(swap), .mux_bip_o(bip), .mux_gain_o(gain),
    .data_o(bus), .data_en_o(den)
  );

  function automatic logic [6:0] mux_now();
    return {diff, addr, swap, bip, gain};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [6:0] w, input logic c);
    @(negedge clk); sel = 1; wr = 1; ctl = c; cfg = w;
    @(negedge clk); sel = 0; wr = 0; ctl = 0;
  endtask

  task automatic rd_word(input logic c, output logic [15:0] v);
    @(negedge clk); sel = 1; rd = 1; ctl = c;
    #1 v = bus;
    chk(den == 1'b1, "R9 enable during read", den, 1);
    @(negedge clk); sel = 0; rd = 0; ctl = 0;
    #1 chk(den == 1'b0, "R9 enable after read", den, 0);
  endtask

  task automatic convert(input logic [11:0] r, input logic [6:0] ecfg, input string tag);
    logic [15:0] v;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1'b1, {tag, " R3 busy"}, busy, 1);
    chk(go == 1'b1, {tag, " R3 go"}, go, 1);
    chk(mux_now() == ecfg, {tag, " R3 mux cfg"}, mux_now(), ecfg);
    @(negedge clk);
    chk(go == 1'b0, {tag, " R3 go single"}, go, 0);
    done = 1; res = r;
    @(negedge clk); done = 0;
    chk(busy == 1'b0, {tag, " R5 busy clear"}, busy, 0);
    rd_word(1'b0, v);
    chk(v == {ecfg[6], ecfg[5:3], r}, {tag, " R5 word"}, v, {ecfg[6], ecfg[5:3], r});
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && go == 0, "R1 idle", {busy, go}, 0);
    chk(den == 0, "R1 bus off", den, 0);
    chk(mux_now() == 7'd0, "R1 mux ch0", mux_now(), 0);
    rd_word(1'b0, v);
    chk(v == 16'h0, "R1 word zero", v, 0);
    rd_word(1'b1, v);
    chk(v == 16'h0, "R1 R10 empty list readback", v, 0);
  endtask

  task automatic t_scan();
    for (int i = 0; i < 9; i++)
      convert(12'h100 + 12'(i), {1'b0, 3'(i % 8), 3'b000}, "R2 scan");
  endtask

  task automatic t_busy_ignore();
    logic [6:0] m;
    logic [15:0] v;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    m = mux_now();
    chk(m == 7'b0_001_000, "R2 scan ch1 after wrap", m, 7'b0_001_000);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(go == 0, "R4 no go while busy", go, 0);
    chk(mux_now() == m, "R4 mux held", mux_now(), m);
    done = 1; res = 12'hABC;
    @(negedge clk); done = 0;
    chk(busy == 0, "R4 busy clear", busy, 0);
    @(negedge clk); done = 1; res = 12'h555;
    @(negedge clk); done = 0;
    rd_word(1'b0, v);
    chk(v == 16'h1ABC, "R5 stray done ignored", v, 16'h1ABC);
  endtask

  task automatic t_program();
    wr_word(7'b1_101_011, 1'b0);
    wr_word(7'b0_010_100, 1'b0);
    wr_word(7'b1_111_001, 1'b0);
    convert(12'h001, 7'b1_101_011, "R6 e0");
    convert(12'h002, 7'b0_010_100, "R6 e1");
    convert(12'h003, 7'b1_111_001, "R6 e2");
    convert(12'h004, 7'b1_101_011, "R6 wrap");
    wr_word(7'b0_110_110, 1'b0);
    convert(12'h005, 7'b1_101_011, "R8 restart after write");
    convert(12'h006, 7'b0_010_100, "R8 e1");
    wr_word(7'b0, 1'b1);
    convert(12'h007, 7'b0_000_000, "R8 clear scan ch0");
    convert(12'h008, 7'b0_001_000, "R8 scan ch1");
  endtask

  task automatic t_full_readback();
    logic [15:0] v;
    wr_word(7'b0, 1'b1);
    for (int i = 0; i < 17; i++) wr_word(7'((i * 37 + 5) & 7'h7f), 1'b0);
    for (int i = 0; i < 17; i++) begin
      logic [6:0] e;
      e = 7'(((i % 16) * 37 + 5) & 7'h7f);
      rd_word(1'b1, v);
      chk(v == {e, 9'b0}, (i == 16) ? "R7 R10 wrap, extra write ignored" : "R10 readback", v, {e, 9'b0});
    end
    for (int i = 0; i < 16; i++) convert(12'(i), 7'((i * 37 + 5) & 7'h7f), "R7 full list");
    convert(12'hFFF, 7'd5, "R7 full wrap");
    @(negedge clk); sel = 0; rd = 1;
    #1 chk(den == 0, "R9 no enable without select", den, 0);
    @(negedge clk); rd = 0;
  endtask

  initial begin
    t_reset();
    t_scan();
    t_busy_ignore();
    t_program();
    t_full_readback();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule